// File: doc/BRIEF.md
# Tagged Bus Drive Command Decoder

This block sits behind the line receivers on the control cable of a disk drive and turns its strobed command protocol into drive state. Four tag strobes share the inputs: one latches a 4-bit unit address, and three others load the same 10-bit bus with different meanings. These are the target cylinder, the head number and a word of control bits. The unit address is compared with the drive's own number, and only a selected drive acts on the three data tags or shows its status.

A cylinder tag starts a seek. A cylinder below the configured limit is accepted, and on-cylinder then drops for a fixed settle window. A cylinder at or above the limit raises seek error. The control tag drives read-gate and write-gate levels that gate the incoming clocks. A rising return-to-zero bit or fault-clear bit gives a one-cycle pulse and its action. The remaining control bits are only held. An open-cable indication blanks every status line and locks out all tags.

Top module: `tagged_drive_ctl`

## Requirements
- R1: Each tag input passes a two-flop synchroniser and acts on its rising edge. The bus or unit field is captured at that edge, and the effect shows after the third rising clock edge from the first edge that sees the tag high.
- R2: The unit tag latches `unit_bus`. `unit_selected` is 1 exactly when a unit has been latched, it equals `my_unit`, and `open_cable` is 0. After reset no unit is selected.
- R3: A cylinder tag with a bus value below CYL_MAX sets `cur_cyl` to that value and clears `seek_error`. `cur_cyl` never reaches CYL_MAX.
- R4: A cylinder tag with a bus value at or above CYL_MAX sets `seek_error` and leaves `cur_cyl` unchanged. `on_cylinder` stays 0 until the next valid seek or return to zero. `seek_error` and `on_cylinder` are never both 1.
- R5: After a valid seek or return to zero, `on_cylinder` is 0 for exactly SETTLE cycles and then returns to 1.
- R6: The head tag latches the bus into `cur_head`.
- R7: The control tag latches the bus into `ctl_bits`. Bit 0 is write gate and bit 1 is read gate. `wr_clk_gated` is `wr_clk_in` AND write gate, and `rd_clk_gated` is `rd_clk_in` AND read gate, both also requiring the unit to be selected.
- R8: Bit 6 is return to zero. A 0-to-1 change of the latched bit gives one cycle of `rtz_pulse`, sets `cur_cyl` to 0, clears `seek_error` and starts the settle window. Loading bit 6 again while it is already 1 does nothing.
- R9: Bit 4 is fault clear. A 0-to-1 change of the latched bit gives one cycle of `fault_clr_pulse` and clears `fault`. Latching write gate while `write_prot_in` is 1 sets `fault`, and a set takes precedence over a clear in the same strobe.
- R10: Bits 2, 3, 5, 7, 8 and 9 appear in `ctl_bits` only and change no other output.
- R11: When the unit is not selected or `open_cable` is 1, the outputs `unit_ready`, `on_cylinder`, `seek_error`, `fault`, `write_protected` and both gated clocks are 0. Cylinder, head and control tags are ignored while unselected, and every tag is ignored while `open_cable` is 1.
- R12: Reset clears `cur_cyl`, `cur_head`, `ctl_bits`, the fault and both pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_unit | input | UNIT_W | This drive's unit number |
| open_cable | input | 1 | Control cable detected open |
| write_prot_in | input | 1 | Media write-protect condition |
| tag_unit | input | 1 | Unit-address strobe |
| tag_cyl | input | 1 | Cylinder strobe |
| tag_head | input | 1 | Head strobe |
| tag_ctl | input | 1 | Control-word strobe |
| unit_bus | input | UNIT_W | Unit-address field |
| cmd_bus | input | BUS_W | Shared command bus |
| wr_clk_in | input | 1 | Write clock from controller |
| rd_clk_in | input | 1 | Read clock from local source |
| wr_clk_gated | output | 1 | Write clock gated by write gate |
| rd_clk_gated | output | 1 | Read clock gated by read gate |
| unit_selected | output | 1 | Unit address matches |
| unit_ready | output | 1 | Drive ready (selected, cable closed) |
| on_cylinder | output | 1 | Heads settled on target |
| seek_error | output | 1 | Last seek out of range |
| fault | output | 1 | Sticky fault |
| write_protected | output | 1 | Write-protect status |
| rtz_pulse | output | 1 | One-cycle return-to-zero event |
| fault_clr_pulse | output | 1 | One-cycle fault-clear event |
| cur_cyl | output | BUS_W | Current cylinder |
| cur_head | output | BUS_W | Current head |
| ctl_bits | output | BUS_W | Latched control word |

## Verification
A tag raised just after a falling edge is seen at the first rising edge. Its registered effects, including the pulses, land at the third rising edge, so the bench drops the tag and samples on the falling edge that follows that third edge. The settle window is checked at the falling edges after SETTLE-1 and SETTLE further rising edges, which is where `on_cylinder` is last low and then first high. The pulses are counted at every falling edge, and the counts are read two falling edges after a strobe, by which time the counter has settled. The gated clocks and the status blanking are combinational, and they are checked one nanosecond after their inputs change.

// File: rtl/drive_cmd_pkg.sv
`timescale 1ns/1ps
package drive_cmd_pkg;

    // Control word carried by the control tag; write gate is bit 0.
    typedef struct packed {
        logic release_req;   // bit 9
        logic strobe_late;   // bit 8
        logic strobe_early;  // bit 7
        logic rtz;           // bit 6
        logic am_enable;     // bit 5
        logic fault_clear;   // bit 4
        logic offset_minus;  // bit 3
        logic offset_plus;   // bit 2
        logic read_gate;     // bit 1
        logic write_gate;    // bit 0
    } ctl_word_t;

    localparam int CTL_W = $bits(ctl_word_t);

    typedef enum logic [1:0] {
        TAG_UNIT = 2'd0,
        TAG_CYL  = 2'd1,
        TAG_HEAD = 2'd2,
        TAG_CTL  = 2'd3
    } tag_idx_e;

    localparam int NUM_TAGS = 4;

    function automatic logic went_high(input logic now_v, input logic was_v);
        return now_v & ~was_v;
    endfunction

endpackage

// File: rtl/tag_sync.sv
`timescale 1ns/1ps
module tag_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] tag_in,
    output logic [N-1:0] tag_rise
);
    import drive_cmd_pkg::*;

    for (genvar i = 0; i < N; i++) begin : g_tag
        logic meta_q, sync_q, prev_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= tag_in[i];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end
        assign tag_rise[i] = went_high(sync_q, prev_q);
    end

endmodule

// File: rtl/seek_ctrl.sv
`timescale 1ns/1ps
module seek_ctrl #(
    parameter int BUS_W   = 10,
    parameter int CYL_MAX = 823,
    parameter int SETTLE  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seek_req,
    input  logic [BUS_W-1:0] seek_addr,
    input  logic             rtz_req,
    output logic [BUS_W-1:0] cyl,
    output logic             on_cyl,
    output logic             seek_err
);
    localparam int CW = $clog2(SETTLE + 1);
    localparam logic [BUS_W:0] LIMIT = (BUS_W + 1)'(CYL_MAX);

    logic [CW-1:0] settle_q;
    logic          addr_bad;

    assign addr_bad = {1'b0, seek_addr} >= LIMIT;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyl      <= '0;
            settle_q <= '0;
            seek_err <= 1'b0;
        end else if (rtz_req) begin
            cyl      <= '0;
            seek_err <= 1'b0;
            settle_q <= CW'(SETTLE);
        end else if (seek_req) begin
            if (addr_bad) begin
                seek_err <= 1'b1;
                settle_q <= '0;
            end else begin
                cyl      <= seek_addr;
                seek_err <= 1'b0;
                settle_q <= CW'(SETTLE);
            end
        end else if (settle_q != '0) begin
            settle_q <= settle_q - 1'b1;
        end
    end

    assign on_cyl = (settle_q == '0) && !seek_err;

endmodule

// File: rtl/ctl_latch.sv
`timescale 1ns/1ps
module ctl_latch #(
    parameter int BUS_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic [BUS_W-1:0] bus,
    input  logic             wp_in,
    output drive_cmd_pkg::ctl_word_t ctl,
    output logic             rtz_now,
    output logic             rtz_pulse,
    output logic             fc_pulse,
    output logic             fault_q
);
    import drive_cmd_pkg::*;

    ctl_word_t next_w;
    logic      fc_now;

    assign next_w  = ctl_word_t'(bus[CTL_W-1:0]);
    assign rtz_now = strobe & went_high(next_w.rtz, ctl.rtz);
    assign fc_now  = strobe & went_high(next_w.fault_clear, ctl.fault_clear);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl       <= '0;
            rtz_pulse <= 1'b0;
            fc_pulse  <= 1'b0;
            fault_q   <= 1'b0;
        end else begin
            rtz_pulse <= rtz_now;
            fc_pulse  <= fc_now;
            if (strobe) ctl <= next_w;
            if (strobe && next_w.write_gate && wp_in) fault_q <= 1'b1;
            else if (fc_now)                         fault_q <= 1'b0;
        end
    end

endmodule

// File: rtl/tagged_drive_ctl.sv
`timescale 1ns/1ps
module tagged_drive_ctl #(
    parameter int BUS_W   = 10,
    parameter int UNIT_W  = 4,
    parameter int CYL_MAX = 823,
    parameter int SETTLE  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [UNIT_W-1:0] my_unit,
    input  logic              open_cable,
    input  logic              write_prot_in,
    input  logic              tag_unit,
    input  logic              tag_cyl,
    input  logic              tag_head,
    input  logic              tag_ctl,
    input  logic [UNIT_W-1:0] unit_bus,
    input  logic [BUS_W-1:0]  cmd_bus,
    input  logic              wr_clk_in,
    input  logic              rd_clk_in,
    output logic              wr_clk_gated,
    output logic              rd_clk_gated,
    output logic              unit_selected,
    output logic              unit_ready,
    output logic              on_cylinder,
    output logic              seek_error,
    output logic              fault,
    output logic              write_protected,
    output logic              rtz_pulse,
    output logic              fault_clr_pulse,
    output logic [BUS_W-1:0]  cur_cyl,
    output logic [BUS_W-1:0]  cur_head,
    output logic [BUS_W-1:0]  ctl_bits
);
    import drive_cmd_pkg::*;

    logic [NUM_TAGS-1:0] rise;
    logic [UNIT_W-1:0]   unit_q;
    logic                unit_valid_q;
    logic                sel_match, status_en;
    logic                on_cyl_raw, seek_err_raw, fault_raw, rtz_now;
    ctl_word_t           ctl;

    tag_sync #(.N(NUM_TAGS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .tag_in   ({tag_ctl, tag_head, tag_cyl, tag_unit}),
        .tag_rise (rise)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            unit_q       <= '0;
            unit_valid_q <= 1'b0;
            cur_head     <= '0;
        end else begin
            if (rise[TAG_UNIT] && !open_cable) begin
                unit_q       <= unit_bus;
                unit_valid_q <= 1'b1;
            end
            if (rise[TAG_HEAD] && status_en) cur_head <= cmd_bus;
        end
    end

    assign sel_match = unit_valid_q && (unit_q == my_unit);
    assign status_en = sel_match && !open_cable;

    seek_ctrl #(.BUS_W(BUS_W), .CYL_MAX(CYL_MAX), .SETTLE(SETTLE)) u_seek (
        .clk       (clk),
        .rst       (rst),
        .seek_req  (rise[TAG_CYL] && status_en),
        .seek_addr (cmd_bus),
        .rtz_req   (rtz_now),
        .cyl       (cur_cyl),
        .on_cyl    (on_cyl_raw),
        .seek_err  (seek_err_raw)
    );

    ctl_latch #(.BUS_W(BUS_W)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .strobe    (rise[TAG_CTL] && status_en),
        .bus       (cmd_bus),
        .wp_in     (write_prot_in),
        .ctl       (ctl),
        .rtz_now   (rtz_now),
        .rtz_pulse (rtz_pulse),
        .fc_pulse  (fault_clr_pulse),
        .fault_q   (fault_raw)
    );

    assign ctl_bits        = BUS_W'(ctl);
    assign unit_selected   = status_en;
    assign unit_ready      = status_en;
    assign on_cylinder     = status_en & on_cyl_raw;
    assign seek_error      = status_en & seek_err_raw;
    assign fault           = status_en & fault_raw;
    assign write_protected = status_en & write_prot_in;
    assign wr_clk_gated    = status_en & ctl.write_gate & wr_clk_in;
    assign rd_clk_gated    = status_en & ctl.read_gate & rd_clk_in;

endmodule

// File: rtl/drive_cmd_checker.sv
`timescale 1ns/1ps
module drive_cmd_checker #(
    parameter int BUS_W   = 10,
    parameter int CYL_MAX = 823
) (
    input logic             clk,
    input logic             rst,
    input logic             open_cable,
    input logic             unit_ready,
    input logic             on_cylinder,
    input logic             seek_error,
    input logic             fault,
    input logic             write_protected,
    input logic             wr_clk_gated,
    input logic             rd_clk_gated,
    input logic             rtz_pulse,
    input logic             fault_clr_pulse,
    input logic [BUS_W-1:0] cur_cyl
);
    localparam logic [BUS_W:0] LIMIT = (BUS_W + 1)'(CYL_MAX);

    assert_cyl_range_R3: assert property (@(posedge clk) disable iff (rst)
        {1'b0, cur_cyl} < LIMIT);

    assert_err_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(seek_error && on_cylinder));

    assert_rtz_single_R8: assert property (@(posedge clk) disable iff (rst)
        rtz_pulse |=> !rtz_pulse);

    assert_rtz_effect_R8: assert property (@(posedge clk) disable iff (rst)
        rtz_pulse |-> (cur_cyl == '0) && !seek_error && !on_cylinder);

    assert_fc_single_R9: assert property (@(posedge clk) disable iff (rst)
        fault_clr_pulse |=> !fault_clr_pulse);

    assert_open_blank_R11: assert property (@(posedge clk) disable iff (rst)
        open_cable |-> !unit_ready && !on_cylinder && !seek_error && !fault
                       && !write_protected && !wr_clk_gated && !rd_clk_gated);

endmodule

bind tagged_drive_ctl drive_cmd_checker #(.BUS_W(BUS_W), .CYL_MAX(CYL_MAX)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .open_cable      (open_cable),
    .unit_ready      (unit_ready),
    .on_cylinder     (on_cylinder),
    .seek_error      (seek_error),
    .fault           (fault),
    .write_protected (write_protected),
    .wr_clk_gated    (wr_clk_gated),
    .rd_clk_gated    (rd_clk_gated),
    .rtz_pulse       (rtz_pulse),
    .fault_clr_pulse (fault_clr_pulse),
    .cur_cyl         (cur_cyl)
);

// File: tb/tagged_drive_ctl_test.sv
`timescale 1ns/1ps
module tagged_drive_ctl_test;
    localparam int BW = 10, UW = 4, CMAX = 20, ST = 4;
    localparam logic [3:0] ME = 4'd5;

    logic clk = 0, rst = 1;
    logic open_cable = 0, wp = 0;
    logic t_unit = 0, t_cyl = 0, t_head = 0, t_ctl = 0;
    logic [UW-1:0] ubus = '0;
    logic [BW-1:0] cbus = '0;
    logic wr_in = 0, rd_in = 0;
    logic wr_g, rd_g, sel, rdy, oncyl, serr, flt, wprot, rtzp, fcp;
    logic [BW-1:0] cyl, head, ctlb;
    int n_chk = 0, n_bad = 0, rtz_cnt = 0, fc_cnt = 0;
    int last_cyl;

    always #2.5 clk = ~clk;

    tagged_drive_ctl #(.BUS_W(BW), .UNIT_W(UW), .CYL_MAX(CMAX), .SETTLE(ST)) uut (
        .clk(clk), .rst(rst), .my_unit(ME), .open_cable(open_cable),
        .write_prot_in(wp), .tag_unit(t_unit), .tag_cyl(t_cyl), .tag_head(t_head),
        .tag_ctl(t_ctl), .unit_bus(ubus), .cmd_bus(cbus), .wr_clk_in(wr_in),
        .rd_clk_in(rd_in), .wr_clk_gated(wr_g), .rd_clk_gated(rd_g),
        .unit_selected(sel), .unit_ready(rdy), .on_cylinder(oncyl),
        .seek_error(serr), .fault(flt), .write_protected(wprot),
        .rtz_pulse(rtzp), .fault_clr_pulse(fcp), .cur_cyl(cyl),
        .cur_head(head), .ctl_bits(ctlb)
    );

    always @(negedge clk) begin
        if (rtzp) rtz_cnt++;
        if (fcp)  fc_cnt++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Raise one tag after a falling edge, hold it through three rising edges,
    // then drop it on the falling edge where the effect is first visible.
    task automatic strobe(input int which, input logic [BW-1:0] v);
        @(negedge clk);
        cbus = v;
        ubus = v[UW-1:0];
        case (which)
            0: t_unit = 1;
            1: t_cyl  = 1;
            2: t_head = 1;
            default: t_ctl = 1;
        endcase
        repeat (3) @(negedge clk);
        t_unit = 0; t_cyl = 0; t_head = 0; t_ctl = 0;
    endtask

    task automatic settle_check(input string req);
        chk({req, " on_cyl low at strobe"}, int'(oncyl), 0);
        repeat (ST - 1) @(negedge clk);
        chk({req, " on_cyl low last settle cycle"}, int'(oncyl), 0);
        @(negedge clk);
        chk({req, " on_cyl high after settle"}, int'(oncyl), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12 reset state
        chk("R12 cyl", int'(cyl), 0);
        chk("R12 head", int'(head), 0);
        chk("R12 ctl", int'(ctlb), 0);
        chk("R12 fault", int'(flt), 0);
        chk("R2 none selected after reset", int'(sel), 0);

        // R2 unit sweep; R1 timing implied by sample point
        for (int u = 0; u < 16; u++) begin
            strobe(0, BW'(u));
            chk($sformatf("R2 R1 select unit %0d", u), int'(sel), int'(u == int'(ME)));
            chk("R11 ready follows select", int'(rdy), int'(u == int'(ME)));
        end
        // unit 15 latched: not selected, seek ignored
        strobe(1, 10'd7);
        repeat (2) @(negedge clk);
        chk("R11 seek ignored unselected", int'(cyl), 0);
        strobe(0, BW'(ME));
        chk("R2 reselect", int'(sel), 1);

        // R3/R4/R5 cylinder sweep
        last_cyl = 0;
        for (int c = 0; c < 32; c++) begin
            strobe(1, BW'(c));
            if (c < CMAX) begin
                last_cyl = c;
                chk($sformatf("R3 cyl %0d", c), int'(cyl), c);
                chk("R3 seek_error clear", int'(serr), 0);
                settle_check("R5");
            end else begin
                chk($sformatf("R4 cyl kept on %0d", c), int'(cyl), last_cyl);
                chk("R4 seek_error set", int'(serr), 1);
                repeat (ST + 1) @(negedge clk);
                chk("R4 on_cyl stays low", int'(oncyl), 0);
            end
        end
        strobe(1, 10'd3);
        chk("R4 valid seek clears error", int'(serr), 0);
        settle_check("R5 after error");

        // R6 head
        for (int h = 0; h < 10; h++) begin
            strobe(2, BW'(h * 97 + 5));
            chk("R6 head", int'(head), h * 97 + 5);
        end

        // R7 gates
        strobe(3, 10'h001);
        wr_in = 1; rd_in = 1; #1;
        chk("R7 ctl bits", int'(ctlb), 1);
        chk("R7 write gate passes", int'(wr_g), 1);
        chk("R7 read gate closed", int'(rd_g), 0);
        wr_in = 0; #1;
        chk("R7 write clock follows", int'(wr_g), 0);
        wr_in = 1;
        strobe(3, 10'h002);
        #1;
        chk("R7 write gate closed", int'(wr_g), 0);
        chk("R7 read gate passes", int'(rd_g), 1);

        // R10 ignored bits
        strobe(3, 10'h3AC);
        repeat (2) @(negedge clk);
        chk("R10 ctl_bits hold", int'(ctlb), 'h3AC);
        chk("R10 gates off", int'(wr_g | rd_g), 0);
        chk("R10 cyl", int'(cyl), 3);
        chk("R10 on_cyl", int'(oncyl), 1);
        chk("R10 seek_error", int'(serr), 0);
        chk("R10 fault", int'(flt), 0);
        chk("R10 no pulses", rtz_cnt + fc_cnt, 0);

        // R8 return to zero
        strobe(1, 10'd12);
        repeat (ST + 1) @(negedge clk);
        strobe(1, 10'd25);
        chk("R8 precondition error", int'(serr), 1);
        strobe(3, 10'h040);
        chk("R8 cyl zero", int'(cyl), 0);
        chk("R8 error cleared", int'(serr), 0);
        settle_check("R8 R5");
        chk("R8 one pulse", rtz_cnt, 1);
        strobe(1, 10'd9);
        repeat (ST + 1) @(negedge clk);
        strobe(3, 10'h040);
        repeat (2) @(negedge clk);
        chk("R8 no retrigger count", rtz_cnt, 1);
        chk("R8 no retrigger cyl", int'(cyl), 9);
        strobe(3, 10'h000);
        strobe(3, 10'h040);
        repeat (2) @(negedge clk);
        chk("R8 second pulse", rtz_cnt, 2);
        chk("R8 cyl zero again", int'(cyl), 0);

        // R9 fault
        wp = 1; #1;
        chk("R9 write_protected shown", int'(wprot), 1);
        strobe(3, 10'h001);
        chk("R9 fault set", int'(flt), 1);
        strobe(3, 10'h011);
        repeat (2) @(negedge clk);
        chk("R9 set wins", int'(flt), 1);
        chk("R9 fc pulse", fc_cnt, 1);
        strobe(3, 10'h000);
        wp = 0;
        strobe(3, 10'h010);
        repeat (2) @(negedge clk);
        chk("R9 fault cleared", int'(flt), 0);
        chk("R9 fc pulse 2", fc_cnt, 2);

        // R11 open cable
        wp = 1;
        strobe(3, 10'h003);
        open_cable = 1; #1;
        chk("R11 open sel", int'(sel), 0);
        chk("R11 open status", int'(rdy | oncyl | serr | wprot | flt), 0);
        chk("R11 open gates", int'(wr_g | rd_g), 0);
        strobe(1, 10'd9);
        strobe(2, 10'd1);
        repeat (2) @(negedge clk);
        chk("R11 open seek ignored", int'(cyl), 0);
        chk("R11 open head ignored", int'(head), 9 * 97 + 5);
        open_cable = 0; #1;
        chk("R11 reselected after close", int'(sel), 1);
        chk("R11 fault now visible", int'(flt), 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule